// File: doc/BRIEF.md
# Parity-Checked Two-Port Memory

A memory of 2^ADDR_W words of DATA_W bits (256 by 9 by default). It has one write port and one read port, each with its own address. The top bit of every word is the parity bit. A single mode input selects the parity rule for the whole block: odd when high, even when low. The write port checks each incoming word against the rule and raises a write error flag when the word breaks it. The word is stored as it arrived in either case. The read port applies the same rule to the word it fetches and raises a read error flag when that word breaks it.

Each port is enabled by an active-low select together with an active-low strobe. A parameter sets each port to synchronous or asynchronous mode, independently of the other. A synchronous port acts on the rising edge of its own clock, and the two port clocks need not be related. An asynchronous write happens on the rising edge of the write strobe. An asynchronous read presents the addressed word combinationally for as long as the read is enabled.

Top module: `par_dpram`

## Requirements
- R1: In synchronous write mode, the word on wr_data is stored at wr_addr on a rising edge of wr_clk only when both wr_sel_n and wr_stb_n are 0. With either of them at 1, no word changes.
- R2: In synchronous read mode, rd_data takes the word at rd_addr on a rising edge of rd_clk when both rd_sel_n and rd_stb_n are 0. Otherwise rd_data keeps its value. While rst_n is 0, rd_data is 0.
- R3: When a synchronous read and a synchronous write hit the same address on the same clock edge, the read returns the word stored before that write.
- R4: wr_perr is 1 exactly when a write is enabled (wr_sel_n and wr_stb_n both 0) and the XOR of all DATA_W bits of wr_data differs from odd_sel. It is combinational, so it is valid in the same cycle as the write, and it is 0 whenever no write is enabled.
- R5: In synchronous read mode, rd_perr is registered together with rd_data. After a read edge it is 1 exactly when the XOR of all bits of the fetched word differs from odd_sel. It is 0 after any edge without a read, and 0 while rst_n is 0.
- R6: odd_sel=1 selects odd parity, meaning the XOR of a correct word is 1. odd_sel=0 selects even parity, meaning the XOR of a correct word is 0. The same rule governs both error flags, so changing odd_sel inverts the check on the same stored word.
- R7: In asynchronous write mode, the word is stored on the rising edge of wr_stb_n when wr_sel_n is 0. A strobe edge while wr_sel_n is 1 stores nothing.
- R8: In asynchronous read mode, while rd_sel_n and rd_stb_n are both 0, rd_data shows the word at rd_addr combinationally and rd_perr shows its parity check. While either input is 1, both outputs are 0.
- R9: A word whose parity is wrong is still stored unchanged. Reading it back returns the same bits and sets rd_perr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock, used in synchronous write mode |
| rd_clk | input | 1 | Read-side clock, used in synchronous read mode |
| rst_n | input | 1 | Active-low asynchronous reset of the registered read outputs |
| odd_sel | input | 1 | Parity rule: 1 selects odd, 0 selects even |
| wr_sel_n | input | 1 | Active-low write port select |
| wr_stb_n | input | 1 | Active-low write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write word; the top bit is the parity bit |
| wr_perr | output | 1 | Parity error on the incoming write word |
| rd_sel_n | input | 1 | Active-low read port select |
| rd_stb_n | input | 1 | Active-low read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read word |
| rd_perr | output | 1 | Parity error on the read word |

## Verification
wr_perr is combinational, so the bench checks it one time unit after it drives the write inputs at the falling edge, before the next rising edge. In synchronous read mode, rd_data and rd_perr are due one edge after the read. The bench works out their expected values from its own memory model before it applies that cycle's write, which also covers the same-address case of R3, and compares them at the following falling edge. The asynchronous-mode instance is checked one time unit after each change of strobe or select, because its read is combinational and its write lands on the rising edge of the strobe.

// File: rtl/par_dpram_pkg.sv
package par_dpram_pkg;

   typedef enum bit {
      PM_ASYNC = 1'b0,
      PM_SYNC  = 1'b1
   } port_mode_e;

   // Error when the XOR over a whole word disagrees with the selected rule
   function automatic logic par_fault(input logic word_xor, input logic odd_rule);
      return word_xor ^ odd_rule;
   endfunction

endpackage

// File: rtl/par_dpram_wport.sv
module par_dpram_wport
   import par_dpram_pkg::*;
#(
   parameter port_mode_e MODE   = PM_SYNC,
   parameter int         DATA_W = 9
) (
   input  logic              wr_clk,
   input  logic              sel_n,
   input  logic              stb_n,
   input  logic              odd_sel,
   input  logic [DATA_W-1:0] data,
   output logic              mem_clk,
   output logic              mem_we,
   output logic              perr
);

   logic active;

   assign active = ~sel_n & ~stb_n;
   assign perr   = active & par_fault(^data, odd_sel);

   generate
      if (MODE == PM_SYNC) begin : g_sync
         assign mem_clk = wr_clk;
         assign mem_we  = active;
      end else begin : g_async
         // The rising (trailing) edge of the strobe commits the word
         assign mem_clk = stb_n;
         assign mem_we  = ~sel_n;
      end
   endgenerate

endmodule

// File: rtl/par_dpram_mem.sv
module par_dpram_mem #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 9
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rword
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         cells[waddr] <= wdata;
      end
   end

   assign rword = cells[raddr];

endmodule

// File: rtl/par_dpram_rport.sv
module par_dpram_rport
   import par_dpram_pkg::*;
#(
   parameter port_mode_e MODE   = PM_SYNC,
   parameter int         DATA_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n,
   input  logic              stb_n,
   input  logic              odd_sel,
   input  logic [DATA_W-1:0] word,
   output logic [DATA_W-1:0] data,
   output logic              perr
);

   logic active;
   logic fault;

   assign active = ~sel_n & ~stb_n;
   assign fault  = par_fault(^word, odd_sel);

   generate
      if (MODE == PM_SYNC) begin : g_sync
         logic [DATA_W-1:0] data_q;
         logic              perr_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               data_q <= '0;
               perr_q <= 1'b0;
            end else begin
               perr_q <= active & fault;
               if (active) begin
                  data_q <= word;
               end
            end
         end

         assign data = data_q;
         assign perr = perr_q;
      end else begin : g_async
         assign data = active ? word : '0;
         assign perr = active & fault;
      end
   endgenerate

endmodule

// File: rtl/par_dpram.sv
module par_dpram
   import par_dpram_pkg::*;
#(
   parameter int         ADDR_W  = 8,
   parameter int         DATA_W  = 9,
   parameter port_mode_e WR_MODE = PM_SYNC,
   parameter port_mode_e RD_MODE = PM_SYNC
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              odd_sel,
   input  logic              wr_sel_n,
   input  logic              wr_stb_n,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_perr,
   input  logic              rd_sel_n,
   input  logic              rd_stb_n,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_perr
);

   logic              mem_clk;
   logic              mem_we;
   logic [DATA_W-1:0] mem_rword;

   par_dpram_wport #(
      .MODE   (WR_MODE),
      .DATA_W (DATA_W)
   ) u_wport (
      .wr_clk  (wr_clk),
      .sel_n   (wr_sel_n),
      .stb_n   (wr_stb_n),
      .odd_sel (odd_sel),
      .data    (wr_data),
      .mem_clk (mem_clk),
      .mem_we  (mem_we),
      .perr    (wr_perr)
   );

   par_dpram_mem #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_mem (
      .clk   (mem_clk),
      .we    (mem_we),
      .waddr (wr_addr),
      .wdata (wr_data),
      .raddr (rd_addr),
      .rword (mem_rword)
   );

   par_dpram_rport #(
      .MODE   (RD_MODE),
      .DATA_W (DATA_W)
   ) u_rport (
      .clk     (rd_clk),
      .rst_n   (rst_n),
      .sel_n   (rd_sel_n),
      .stb_n   (rd_stb_n),
      .odd_sel (odd_sel),
      .word    (mem_rword),
      .data    (rd_data),
      .perr    (rd_perr)
   );

endmodule

// File: rtl/par_dpram_chk.sv
module par_dpram_chk
   import par_dpram_pkg::*;
#(
   parameter int         ADDR_W  = 8,
   parameter int         DATA_W  = 9,
   parameter port_mode_e WR_MODE = PM_SYNC,
   parameter port_mode_e RD_MODE = PM_SYNC
) (
   input logic              wr_clk,
   input logic              rd_clk,
   input logic              rst_n,
   input logic              odd_sel,
   input logic              wr_sel_n,
   input logic              wr_stb_n,
   input logic              wr_perr,
   input logic              rd_sel_n,
   input logic              rd_stb_n,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_perr
);

   initial begin
      a_data_width_ok : assert (DATA_W >= 2)
         else $error("DATA_W must leave room for a parity bit");
      a_addr_width_ok : assert (ADDR_W >= 1 && ADDR_W <= 12)
         else $error("ADDR_W out of supported range");
   end

   generate
      if (RD_MODE == PM_SYNC) begin : g_rd_sync
         // R5: no read on an edge leaves the read error flag low
         p_idle_clears_perr_r5 : assert property (@(posedge rd_clk) disable iff (!rst_n)
            (rd_sel_n || rd_stb_n) |=> !rd_perr);
         // R2: no read on an edge leaves the read word unchanged
         p_idle_holds_data_r2 : assert property (@(posedge rd_clk) disable iff (!rst_n)
            (rd_sel_n || rd_stb_n) |=> $stable(rd_data));
         // R6: after a read, the flag agrees with the word that came out
         p_perr_matches_word_r6 : assert property (@(posedge rd_clk) disable iff (!rst_n)
            (!rd_sel_n && !rd_stb_n) |=> (rd_perr == ((^rd_data) ^ $past(odd_sel))));
      end
      if (WR_MODE == PM_SYNC) begin : g_wr_sync
         // R4: a write error can only be raised by an enabled write
         p_wr_perr_gated_r4 : assert property (@(posedge wr_clk) disable iff (!rst_n)
            wr_perr |-> (!wr_sel_n && !wr_stb_n));
      end
   endgenerate

endmodule

bind par_dpram par_dpram_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .WR_MODE (WR_MODE),
   .RD_MODE (RD_MODE)
) u_chk (
   .wr_clk   (wr_clk),
   .rd_clk   (rd_clk),
   .rst_n    (rst_n),
   .odd_sel  (odd_sel),
   .wr_sel_n (wr_sel_n),
   .wr_stb_n (wr_stb_n),
   .wr_perr  (wr_perr),
   .rd_sel_n (rd_sel_n),
   .rd_stb_n (rd_stb_n),
   .rd_data  (rd_data),
   .rd_perr  (rd_perr)
);

// File: tb/test_par_dpram.sv
module test_par_dpram;
   import par_dpram_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 8;
   localparam int DW = 9;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic          rst_n = 1'b0;
   logic          odd_sel = 1'b0;
   logic          wsel_n = 1'b1, wstb_n = 1'b1, rsel_n = 1'b1, rstb_n = 1'b1;
   logic [AW-1:0] waddr = '0, raddr = '0;
   logic [DW-1:0] wdata = '0;
   logic          wperr, rperr;
   logic [DW-1:0] rdata;

   logic          a_wsel_n = 1'b1, a_wstb_n = 1'b1, a_rsel_n = 1'b1, a_rstb_n = 1'b1;
   logic [AW-1:0] a_waddr = '0, a_raddr = '0;
   logic [DW-1:0] a_wdata = '0;
   logic          a_wperr, a_rperr;
   logic [DW-1:0] a_rdata;

   par_dpram #(.ADDR_W(AW), .DATA_W(DW), .WR_MODE(PM_SYNC), .RD_MODE(PM_SYNC)) i_par_dpram (
      .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .odd_sel(odd_sel),
      .wr_sel_n(wsel_n), .wr_stb_n(wstb_n), .wr_addr(waddr), .wr_data(wdata), .wr_perr(wperr),
      .rd_sel_n(rsel_n), .rd_stb_n(rstb_n), .rd_addr(raddr), .rd_data(rdata), .rd_perr(rperr)
   );

   par_dpram #(.ADDR_W(AW), .DATA_W(DW), .WR_MODE(PM_ASYNC), .RD_MODE(PM_ASYNC)) i_par_dpram_async (
      .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .odd_sel(odd_sel),
      .wr_sel_n(a_wsel_n), .wr_stb_n(a_wstb_n), .wr_addr(a_waddr), .wr_data(a_wdata), .wr_perr(a_wperr),
      .rd_sel_n(a_rsel_n), .rd_stb_n(a_rstb_n), .rd_addr(a_raddr), .rd_data(a_rdata), .rd_perr(a_rperr)
   );

   int checks = 0;
   int errors = 0;
   logic [DW-1:0] model [DEPTH];
   logic [DW-1:0] exp_rdata = '0;
   logic          exp_rperr = 1'b0;

   function automatic logic bad_par(input logic [DW-1:0] w, input logic odd);
      // even rule: XOR of a good word is 0; odd rule: XOR of a good word is 1
      return (^w) != odd;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One synchronous cycle: check last edge's read, drive, check write flag, predict
   task automatic cycle(input logic s_w, input logic t_w, input logic [AW-1:0] wa,
                        input logic [DW-1:0] wd, input logic s_r, input logic t_r,
                        input logic [AW-1:0] ra, input logic odd, input string tag);
      logic we, re;
      @(negedge clk);
      check({tag, " R2 rd_data"}, 32'(rdata), 32'(exp_rdata));
      check({tag, " R5 rd_perr"}, 32'(rperr), 32'(exp_rperr));
      wsel_n = s_w; wstb_n = t_w; waddr = wa; wdata = wd;
      rsel_n = s_r; rstb_n = t_r; raddr = ra; odd_sel = odd;
      we = !s_w && !t_w;
      re = !s_r && !t_r;
      #1;
      check({tag, " R4 wr_perr"}, 32'(wperr), 32'(we ? bad_par(wd, odd) : 1'b0));
      if (re) begin
         exp_rdata = model[ra];
         exp_rperr = bad_par(model[ra], odd);
      end else begin
         exp_rperr = 1'b0;
      end
      if (we) model[wa] = wd;
   endtask

   bit done = 0;

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check("R2 reset rd_data", 32'(rdata), 32'h0);
      check("R5 reset rd_perr", 32'(rperr), 32'h0);
      rst_n = 1'b1;

      // Fill every word so that later reads are defined (R1)
      for (int i = 0; i < DEPTH; i++) begin
         cycle(1'b0, 1'b0, AW'(i), DW'($urandom), 1'b1, 1'b1, '0, 1'($urandom), "R1 fill");
      end

      // Random traffic on both ports (R1 R2 R3 R4 R5 R6)
      for (int i = 0; i < 3000; i++) begin
         cycle(1'($urandom), 1'($urandom), AW'($urandom), DW'($urandom),
               1'($urandom), 1'($urandom), AW'($urandom), 1'($urandom), "rand");
      end

      // R3: same address, same edge, read returns the old word
      cycle(1'b0, 1'b0, 8'd5, 9'h0AA, 1'b1, 1'b1, 8'd0, 1'b0, "R3 setup");
      cycle(1'b0, 1'b0, 8'd5, 9'h155, 1'b0, 1'b0, 8'd5, 1'b0, "R3 collide");
      cycle(1'b1, 1'b1, 8'd0, 9'h000, 1'b0, 1'b0, 8'd5, 1'b0, "R3 reread");
      cycle(1'b1, 1'b1, 8'd0, 9'h000, 1'b1, 1'b1, 8'd0, 1'b0, "R3 idle");
      @(negedge clk);
      check("R3 new word after collide", 32'(rdata), 32'h155);

      // R1: select high blocks the write; R9 bad parity word still stored
      cycle(1'b0, 1'b0, 8'd7, 9'h003, 1'b1, 1'b1, 8'd0, 1'b0, "R1 base");
      cycle(1'b1, 1'b0, 8'd7, 9'h1FF, 1'b1, 1'b1, 8'd0, 1'b0, "R1 blocked sel");
      cycle(1'b0, 1'b1, 8'd7, 9'h1FF, 1'b1, 1'b1, 8'd0, 1'b0, "R1 blocked stb");
      cycle(1'b1, 1'b1, 8'd0, 9'h000, 1'b0, 1'b0, 8'd7, 1'b0, "R1 read back");
      cycle(1'b0, 1'b0, 8'd9, 9'h001, 1'b1, 1'b1, 8'd0, 1'b0, "R9 bad write");
      cycle(1'b1, 1'b1, 8'd0, 9'h000, 1'b0, 1'b0, 8'd9, 1'b0, "R9 read even");
      cycle(1'b1, 1'b1, 8'd0, 9'h000, 1'b0, 1'b0, 8'd9, 1'b1, "R6 read odd");
      cycle(1'b1, 1'b1, 8'd0, 9'h000, 1'b1, 1'b1, 8'd0, 1'b0, "R5 idle");
      @(negedge clk);
      check("R5 cleared after idle", 32'(rperr), 32'h0);

      // Asynchronous instance
      a_waddr = 8'd3; a_wdata = 9'h101; odd_sel = 1'b0; a_wsel_n = 1'b0;
      #2 a_wstb_n = 1'b0;
      #1 check("R4 async wr_perr even", 32'(a_wperr), 32'h0);
      odd_sel = 1'b1;
      #1 check("R6 async wr_perr odd", 32'(a_wperr), 32'h1);
      #1 a_wstb_n = 1'b1;
      #1 check("R4 async wr_perr idle", 32'(a_wperr), 32'h0);
      a_wsel_n = 1'b1;
      #1 a_raddr = 8'd3; a_rsel_n = 1'b0; a_rstb_n = 1'b0;
      #1 check("R7 async write stored", 32'(a_rdata), 32'h101);
      check("R8 async rd_perr odd", 32'(a_rperr), 32'h1);
      odd_sel = 1'b0;
      #1 check("R8 async rd_perr even", 32'(a_rperr), 32'h0);
      a_rstb_n = 1'b1;
      #1 check("R8 async idle rd_data", 32'(a_rdata), 32'h0);
      check("R8 async idle rd_perr", 32'(a_rperr), 32'h0);
      // R7: strobe edge with select high stores nothing
      a_wdata = 9'h0F0;
      #1 a_wstb_n = 1'b0;
      #1 a_wstb_n = 1'b1;
      #1 a_rstb_n = 1'b0;
      #1 check("R7 async blocked write", 32'(a_rdata), 32'h101);
      a_rstb_n = 1'b1; a_rsel_n = 1'b1;

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule